// File: doc/BRIEF.md
# Per-Channel DAC Silence Auto-Mute Detector

This block watches the sample streams of six digital-to-analog channels and decides, channel by channel, when a stream has gone silent. A sample is silent (static) when every bit is zero or every bit is one, which is zero or minus one in two's complement. Each channel keeps its own count of consecutive static samples. Once the count reaches the threshold, the channel is flagged as muted, provided automatic muting is enabled. A single sample with any other value clears that channel's count and releases its mute on the same clock edge.

Each channel also has a force bit that mutes it no matter what the data holds. The per-channel mute flags are combined into one external mute pin. A mapping mask selects which channels take part. The pin is active when every mapped channel is muted, and it is also active when no channel is mapped. A polarity input selects whether the active level is high or low. Soft ramping and the actual attenuation of the output are handled elsewhere.

Top module: `dac_silence_mute`

## Requirements
- R1: A strobed sample counts as static when all SAMPLE_W bits are 0 or all are 1. A run that alternates between the two values still counts. Cycles with `smp_valid` low neither advance nor clear any count.
- R2: With `auto_en` high, `ch_muted[c]` rises right after the clock edge that captures the RUN_LEN-th (default 8192) consecutive static strobed sample of channel c. It stays low after RUN_LEN-1 such samples.
- R3: A strobed non-static sample on channel c clears `ch_muted[c]` right after that edge, unless the channel is forced. Muting again then needs a complete new run of RUN_LEN static samples.
- R4: Detection and muting are independent per channel. Channel c uses bits [c*SAMPLE_W +: SAMPLE_W] of `smp_data`, and activity on one channel never changes another channel's flag.
- R5: While `auto_en` is low, no channel is muted automatically, but run counting continues. Raising `auto_en` after a completed run mutes that channel immediately, with no clock edge needed.
- R6: `force_mute[c]` high makes `ch_muted[c]` high in the same cycle, whatever the sample data.
- R7: `mute_pin` is registered and reflects the state one clock after the inputs. It is at the active level when every channel with `pin_map[c]`=1 is muted, and at the inactive level otherwise. The active level is 1 when `pin_active_high`=1 and 0 when it is 0.
- R8: With `pin_map` all zero, `mute_pin` is driven to the active level.
- R9: While reset is asserted and after its release, all run counts are zero and `mute_pin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: one new sample for every channel this cycle |
| smp_data | input | NUM_CH*SAMPLE_W | Packed samples, channel c at [c*SAMPLE_W +: SAMPLE_W] |
| auto_en | input | 1 | Enables automatic muting |
| force_mute | input | NUM_CH | Per-channel forced mute |
| pin_map | input | NUM_CH | Channels that take part in the mute pin |
| pin_active_high | input | 1 | 1: pin active high, 0: pin active low |
| ch_muted | output | NUM_CH | Per-channel mute flags |
| mute_pin | output | 1 | Combined external mute indicator |

## Verification
The assertions assume that `smp_data` is stable and defined whenever `smp_valid` is high. They also assume the control inputs are stable and defined across each sampling edge. The bench changes every input only on the falling clock edge, so both conditions hold. The stimulus mixes long alternating zero and minus-one runs, which cross the threshold exactly, with random traffic in which non-static samples are rare. That rarity lets single channels reach the threshold on their own. The bench sometimes drops the strobe and only occasionally flips the enable, force, mapping and polarity inputs, so every flag and pin transition appears under known conditions.

// File: rtl/dac_mute_pkg.sv
package dac_mute_pkg;
  typedef enum logic {
    PIN_ACT_LOW  = 1'b0,
    PIN_ACT_HIGH = 1'b1
  } pin_pol_e;

  function automatic logic pin_level(input pin_pol_e pol, input logic active);
    pin_level = (pol == PIN_ACT_HIGH) ? active : ~active;
  endfunction
endpackage

// File: rtl/dms_static_det.sv
module dms_static_det #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                is_static
);
  logic all_zero;
  logic all_one;

  always_comb begin
    all_zero  = ~(|sample);
    all_one   = &sample;
    is_static = all_zero | all_one;
  end
endmodule

// File: rtl/dms_run_ctr.sv
module dms_run_ctr #(
  parameter int RUN_LEN = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic is_static,
  output logic run_done
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = smp_valid;
    cnt_d  = cnt_q;
    if (!is_static) begin
      cnt_d = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign run_done = (cnt_q == LIMIT);

  // R3: a non-static strobed sample restarts the run
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !is_static) |=> (cnt_q == '0));

  // R2: each static strobed sample below the limit advances the run by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && is_static && !run_done) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: the run saturates once reached
  p_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && !(smp_valid && !is_static)) |=> run_done);

  // R1: cycles without a strobe leave the run untouched
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid) |=> $stable(cnt_q));
endmodule

// File: rtl/dms_pin_combine.sv
module dms_pin_combine
  import dac_mute_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_muted,
  input  logic [NUM_CH-1:0] pin_map,
  input  logic              pin_active_high,
  output logic              mute_pin
);
  pin_pol_e pol;
  logic     all_mapped_muted;
  logic     pin_d;
  logic     pin_q;

  always_comb begin
    pol              = pin_pol_e'(pin_active_high);
    // unmapped channels read as muted, so an empty map yields active
    all_mapped_muted = &(ch_muted | ~pin_map);
    pin_d            = pin_level(pol, all_mapped_muted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign mute_pin = pin_q;

  // R8: nothing mapped drives the active level
  p_nomap_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_map == '0) |=> (mute_pin == $past(pin_active_high)));

  // R7: any mapped channel still playing keeps the pin inactive
  p_open_channel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_map & ~ch_muted) != '0) |=> (mute_pin == !$past(pin_active_high)));

  // R7: all mapped channels muted gives the active level
  p_all_muted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_map & ~ch_muted) == '0) |=> (mute_pin == $past(pin_active_high)));
endmodule

// File: rtl/dac_silence_mute.sv
module dac_silence_mute #(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
  input  logic                         auto_en,
  input  logic [NUM_CH-1:0]            force_mute,
  input  logic [NUM_CH-1:0]            pin_map,
  input  logic                         pin_active_high,
  output logic [NUM_CH-1:0]            ch_muted,
  output logic                         mute_pin
);
  logic [NUM_CH-1:0] ch_static;
  logic [NUM_CH-1:0] ch_run_done;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dms_static_det #(
      .SAMPLE_W (SAMPLE_W)
    ) u_det (
      .sample    (smp_data[c*SAMPLE_W +: SAMPLE_W]),
      .is_static (ch_static[c])
    );

    dms_run_ctr #(
      .RUN_LEN (RUN_LEN)
    ) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .is_static (ch_static[c]),
      .run_done  (ch_run_done[c])
    );
  end

  always_comb begin
    ch_muted = force_mute | ({NUM_CH{auto_en}} & ch_run_done);
  end

  dms_pin_combine #(
    .NUM_CH (NUM_CH)
  ) u_pin (
    .clk             (clk),
    .rst_n           (rst_n),
    .ch_muted        (ch_muted),
    .pin_map         (pin_map),
    .pin_active_high (pin_active_high),
    .mute_pin        (mute_pin)
  );

  // R6: a forced channel always reads as muted
  p_force_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_mute & ~ch_muted) == '0));

  // R5: with automatic muting off only the force bits mute
  p_auto_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en) |-> (ch_muted == force_mute));

  // R3: an unforced channel given a non-static sample is unmuted after the edge
  p_unmute_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !ch_static[0] && !force_mute[0]) |=> !(ch_muted[0] && !force_mute[0]));
endmodule

// File: tb/dac_silence_mute_tb_top.sv
module dac_silence_mute_tb_top;
  localparam int NCH   = 6;
  localparam int SW    = 24;
  localparam int RUN   = 8192;
  localparam int LIMIT = 200000;

  logic              clk;
  logic              rst_n;
  logic              smp_valid;
  logic [NCH*SW-1:0] smp_data;
  logic              auto_en;
  logic [NCH-1:0]    force_mute;
  logic [NCH-1:0]    pin_map;
  logic              pin_active_high;
  logic [NCH-1:0]    ch_muted;
  logic              mute_pin;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mcnt [NCH];
  logic exp_pin;

  dac_silence_mute #(.NUM_CH(NCH), .SAMPLE_W(SW), .RUN_LEN(RUN)) dut_i (
    .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid), .smp_data (smp_data),
    .auto_en (auto_en), .force_mute (force_mute), .pin_map (pin_map),
    .pin_active_high (pin_active_high), .ch_muted (ch_muted), .mute_pin (mute_pin)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic is_static_val(input logic [SW-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  function automatic logic [NCH-1:0] exp_muted();
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++)
      m[c] = force_mute[c] | (auto_en & (mcnt[c] == RUN));
    return m;
  endfunction

  function automatic logic exp_pin_next();
    logic act;
    act = &(exp_muted() | ~pin_map);
    return pin_active_high ? act : ~act;
  endfunction

  function automatic logic [SW-1:0] nonstatic_val();
    logic [SW-1:0] v;
    v = SW'($urandom);
    if (is_static_val(v)) v = SW'(1);
    return v;
  endfunction

  // one clock: inputs already driven; model updated at the edge, checked at the falling edge
  task automatic tick(input string tag);
    logic pn;
    pn = exp_pin_next();
    @(posedge clk);
    if (smp_valid) begin
      for (int c = 0; c < NCH; c++) begin
        if (!is_static_val(smp_data[c*SW +: SW])) mcnt[c] = 0;
        else if (mcnt[c] < RUN) mcnt[c]++;
      end
    end
    exp_pin = pn;
    @(negedge clk);
    chk({tag, " ch_muted"}, 32'(ch_muted), 32'(exp_muted()));
    chk({tag, " mute_pin"}, 32'(mute_pin), 32'(exp_pin));
  endtask

  task automatic set_all_static(input logic ones);
    for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = ones ? '1 : '0;
  endtask

  // n strobed static samples alternating 0 and -1, with unstrobed garbage cycles between
  task automatic static_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (i % 1500 == 700) begin
        smp_valid = 1'b0;
        for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = nonstatic_val();
        tick("R1 idle cycle");
      end
      smp_valid = 1'b1;
      set_all_static(i[0]);
      tick(tag);
    end
    smp_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) mcnt[c] = 0;
    exp_pin         = 1'b0;
    rst_n           = 1'b0;
    smp_valid       = 1'b0;
    smp_data        = '0;
    auto_en         = 1'b1;
    force_mute      = '0;
    pin_map         = '1;
    pin_active_high = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 pin in reset", 32'(mute_pin), 32'd0);
    chk("R9 flags in reset", 32'(ch_muted), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 pin after reset", 32'(mute_pin), 32'd0);
    chk("R9 flags after reset", 32'(ch_muted), 32'd0);

    // R1/R2: alternating run one short of the threshold, then the last sample
    static_run(RUN - 1, "R1 R2 run");
    chk("R2 not muted at RUN-1", 32'(ch_muted), 32'd0);
    smp_valid = 1'b1; set_all_static(1'b0);
    tick("R2 final sample");
    smp_valid = 1'b0;
    chk("R2 muted at RUN", 32'(ch_muted), 32'h3f);
    chk("R7 pin one cycle later still inactive", 32'(mute_pin), 32'd0);
    tick("R7 pin settle");
    chk("R7 pin active all muted", 32'(mute_pin), 32'd1);

    // R3/R4: one non-static sample on channel 2 only
    smp_valid = 1'b1; set_all_static(1'b1);
    smp_data[2*SW +: SW] = 24'h000100;
    tick("R3 release");
    chk("R3 R4 only ch2 released", 32'(ch_muted), 32'h3b);
    smp_valid = 1'b0;
    tick("R7 pin drop");
    chk("R7 pin inactive with ch2 open", 32'(mute_pin), 32'd0);

    // R3: restart needs a full run
    static_run(RUN - 1, "R3 rerun");
    chk("R3 ch2 still open at RUN-1", 32'(ch_muted), 32'h3b);
    smp_valid = 1'b1; set_all_static(1'b1);
    tick("R3 rerun last");
    smp_valid = 1'b0;
    chk("R3 ch2 muted after full rerun", 32'(ch_muted), 32'h3f);

    // R5: disable and re-enable
    auto_en = 1'b0;
    tick("R5 disabled");
    chk("R5 no auto mute while disabled", 32'(ch_muted), 32'd0);
    smp_valid = 1'b1; set_all_static(1'b0);
    tick("R5 counting while disabled");
    smp_valid = 1'b0;
    auto_en = 1'b1;
    #1;
    chk("R5 immediate mute on enable", 32'(ch_muted), 32'h3f);
    tick("R5 reenabled");

    // R6: force with live data on channel 4
    smp_valid = 1'b1; set_all_static(1'b0);
    smp_data[4*SW +: SW] = 24'h7fffff;
    force_mute = 6'b010000;
    tick("R6 force");
    chk("R6 forced ch4 muted despite data", 32'(ch_muted[4]), 32'd1);
    smp_valid = 1'b0;
    force_mute = '0;
    tick("R6 force off");
    chk("R6 ch4 open once force drops", 32'(ch_muted[4]), 32'd0);

    // R7: mapping excludes the open channel; polarity low
    pin_map = 6'b101111;
    tick("R7 remap");
    tick("R7 remap settle");
    chk("R7 pin active with open ch unmapped", 32'(mute_pin), 32'd1);
    pin_active_high = 1'b0;
    tick("R7 low pol");
    tick("R7 low pol settle");
    chk("R7 active low level", 32'(mute_pin), 32'd0);

    // R8: nothing mapped
    pin_map = '0;
    pin_active_high = 1'b1;
    auto_en = 1'b0;
    tick("R8 nomap");
    tick("R8 nomap settle");
    chk("R8 empty map drives active high", 32'(mute_pin), 32'd1);
    pin_active_high = 1'b0;
    tick("R8 nomap low");
    tick("R8 nomap low settle");
    chk("R8 empty map drives active low", 32'(mute_pin), 32'd0);
    auto_en = 1'b1;
    pin_map = '1;

    // R4: random traffic, channels reach the threshold independently
    for (int i = 0; i < 60000; i++) begin
      if (i % 4000 == 3999) begin
        auto_en         = ($urandom % 5) != 0;
        force_mute      = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
        pin_map         = NCH'($urandom);
        pin_active_high = $urandom % 2;
      end
      smp_valid = ($urandom % 4) != 0;
      for (int c = 0; c < NCH; c++) begin
        if (($urandom % (3000 * (c + 1))) == 0) smp_data[c*SW +: SW] = nonstatic_val();
        else smp_data[c*SW +: SW] = ($urandom % 2) ? '1 : '0;
      end
      tick("R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule